// File: doc/BRIEF.md
# Cascadable Bit-Slice ALU Array

This block is a microprogrammed datapath made of identical 4-bit slices placed side by side to form a wider word. The default is eight slices, giving 32 bits. Each slice holds its own nibble of a 16-entry register file and of a Q working register, and has its own 4-bit ALU. Every slice receives the same source, function and destination fields and the same register addresses. The array around the slices provides three kinds of glue. The carry chain can run in ripple mode or through a two-level group propagate/generate lookahead tree. A word-level zero flag is formed from the per-slice nonzero flags. Boundary multiplexers pick the bit that enters each end of the word during a shift.

The ALU result and all flags are combinational from the current register contents and the control fields. Register-file and Q writes take effect on the next rising clock edge. A sequencer outside the block presents one microinstruction per cycle. The `carry_la` input chooses between the two carry networks, and both networks give identical results. Lookahead mode supports up to sixteen slices: four slices per first-level group and four groups at the second level.

Top module: `bitslice_alu_array`

## Requirements
- R1: While `rst_n` is low, every register-file word and Q are cleared to zero. After reset, every one of them reads back as 0.
- R2: Arithmetic functions take `c_in` as the carry into bit 0. Code 0 computes R+S, code 1 computes S+~R, and code 2 computes R+~S. `c_out` is the carry out of the most significant bit.
- R3: Logic functions produce no carry and no overflow (`c_out`=0, `ovf`=0). Code 3 is R|S, 4 is R&S, 5 is R^S, 6 is ~(R^S) and 7 passes R.
- R4: The source field picks the operand pair (R,S) as follows: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A and B are the registers addressed by `a_addr` and `b_addr`.
- R5: The destination field controls writes and the output as follows. 0 writes F to Q. 1 writes nothing. 2 writes F to register B and outputs A. 3 writes F to register B. 4 writes F>>1 to B and Q>>1 to Q. 5 writes F>>1 to B. 6 writes F<<1 to B and Q<<1 to Q. 7 writes F<<1 to B. Every code except 2 outputs F on `y`.
- R6: Ripple mode (`carry_la`=0) and lookahead mode (`carry_la`=1) give identical `y`, `c_out`, `zero`, `sign` and `ovf` for every input.
- R7: `zero` is 1 exactly when every bit of the ALU result F is 0, including for destination code 2.
- R8: `sign` is F[W-1]. `ovf` is the carry into the top bit XOR the carry out of it.
- R9: On a right shift, the bit that enters the top of the register-file word is set by `msb_fill_sel`: 0 gives zero, 1 gives one, 2 gives F[0] (rotate) and 3 gives F[W-1] (arithmetic).
- R10: On a left shift, the bit that enters bit 0 of the register-file word is set by `lsb_fill_sel`: 0 gives zero, 1 gives one, 2 gives F[W-1] (rotate) and 3 gives zero (arithmetic).
- R11: Q shifts use the same fill selects, with the rotate and arithmetic bits taken from Q.
- R12: Destination code 1 leaves the register file and Q unchanged.
- R13: Carries cross slice boundaries, so adding 1 to all-ones gives 0 with `c_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| carry_la | input | 1 | 1 selects the lookahead carry tree, 0 selects ripple |
| a_addr | input | 4 | Register-file read address A |
| b_addr | input | 4 | Register-file read/write address B |
| src_sel | input | 3 | Operand pair select |
| fn_sel | input | 3 | ALU function select |
| dst_sel | input | 3 | Destination and output select |
| d_in | input | 32 | External data operand |
| c_in | input | 1 | Carry into bit 0 |
| msb_fill_sel | input | 2 | Fill source for the top bit on right shifts |
| lsb_fill_sel | input | 2 | Fill source for bit 0 on left shifts |
| y | output | 32 | Data output |
| c_out | output | 1 | Carry out of the word |
| zero | output | 1 | ALU result is all zero |
| sign | output | 1 | Top bit of the ALU result |
| ovf | output | 1 | Two's-complement overflow |

## Verification
The bench attacks the carry chain at slice seams in two ways. It adds 1 to all-ones, and it runs hundreds of random microinstructions in both carry modes. A broken group generate or a wrong second-level carry would show up as a mismatch in only one mode. It drives signed overflow at 0x7FFFFFFF+1: a design that took overflow from a lower slice, or from the carry out alone, would report the wrong flag there. It runs every fill code on register and Q shifts in both directions, and reads the results back. A wrong neighbour bit at a slice seam, or a rotate taken from the wrong end, would corrupt the stored word. It also checks a subtract of equal operands with destination code 2, where a zero flag derived from `y` instead of F would fail.

// File: rtl/bitslice_pkg.sv
package bitslice_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        SRC_AQ = 3'd0, SRC_AB = 3'd1, SRC_ZQ = 3'd2, SRC_ZB = 3'd3,
        SRC_ZA = 3'd4, SRC_DA = 3'd5, SRC_DQ = 3'd6, SRC_DZ = 3'd7
    } src_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0, FN_SUBR = 3'd1, FN_SUBS = 3'd2, FN_OR   = 3'd3,
        FN_AND  = 3'd4, FN_XOR  = 3'd5, FN_XNOR = 3'd6, FN_PASS = 3'd7
    } fn_e;

    typedef enum logic [2:0] {
        DST_QREG  = 3'd0, DST_NOP  = 3'd1, DST_RAMA = 3'd2, DST_RAMF = 3'd3,
        DST_RAMQD = 3'd4, DST_RAMD = 3'd5, DST_RAMQU = 3'd6, DST_RAMU = 3'd7
    } dst_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0, FILL_ONE = 2'd1, FILL_ROT = 2'd2, FILL_ARITH = 2'd3
    } fill_e;
endpackage

// File: rtl/bitslice_lookahead.sv
module bitslice_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         cin,
    output logic [N-1:0] c,
    output logic         grp_p,
    output logic         grp_g
);
    // Sum-of-products carry for each member: every term is independent,
    // so depth is two levels regardless of position.
    always_comb begin
        logic acc;
        logic term;
        for (int j = 0; j < N; j++) begin
            term = cin;
            for (int k = 0; k < j; k++) term = term & p[k];
            acc = term;
            for (int k = 0; k < j; k++) begin
                term = g[k];
                for (int m = k + 1; m < j; m++) term = term & p[m];
                acc = acc | term;
            end
            c[j] = acc;
        end
        grp_p = &p;
        grp_g = 1'b0;
        for (int k = 0; k < N; k++) begin
            term = g[k];
            for (int m = k + 1; m < N; m++) term = term & p[m];
            grp_g = grp_g | term;
        end
    end
endmodule

// File: rtl/bitslice_carry_tree.sv
module bitslice_carry_tree #(
    parameter int NUM_SLICES = 8,
    localparam int GROUP  = 4,
    localparam int NGRP   = (NUM_SLICES + GROUP - 1) / GROUP,
    localparam int PADDED = NGRP * GROUP
) (
    input  logic [NUM_SLICES-1:0] gp,
    input  logic [NUM_SLICES-1:0] gg,
    input  logic                  cin,
    output logic [NUM_SLICES-1:0] c,
    output logic                  cout
);
    logic [PADDED-1:0] gp_pad;
    logic [PADDED-1:0] gg_pad;
    logic [PADDED-1:0] c_pad;
    logic [NGRP-1:0]   lvl1_p;
    logic [NGRP-1:0]   lvl1_g;
    logic [NGRP-1:0]   grp_cin;

    // Absent slices are transparent: propagate 1, generate 0.
    always_comb begin
        gp_pad = '1;
        gg_pad = '0;
        gp_pad[NUM_SLICES-1:0] = gp;
        gg_pad[NUM_SLICES-1:0] = gg;
    end

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_lvl1
        bitslice_lookahead #(.N(GROUP)) u_la1 (
            .p    (gp_pad[gi*GROUP +: GROUP]),
            .g    (gg_pad[gi*GROUP +: GROUP]),
            .cin  (grp_cin[gi]),
            .c    (c_pad[gi*GROUP +: GROUP]),
            .grp_p(lvl1_p[gi]),
            .grp_g(lvl1_g[gi])
        );
    end

    if (NGRP > 1) begin : g_lvl2
        logic top_p;
        logic top_g;
        bitslice_lookahead #(.N(NGRP)) u_la2 (
            .p    (lvl1_p),
            .g    (lvl1_g),
            .cin  (cin),
            .c    (grp_cin),
            .grp_p(top_p),
            .grp_g(top_g)
        );
        assign cout = top_g | (top_p & cin);
    end else begin : g_single
        assign grp_cin[0] = cin;
        assign cout = lvl1_g[0] | (lvl1_p[0] & cin);
    end

    assign c = c_pad[NUM_SLICES-1:0];
endmodule

// File: rtl/bitslice_slice.sv
module bitslice_slice
    import bitslice_pkg::*;
#(
    parameter int NREG = 16,
    localparam int AW = $clog2(NREG),
    localparam int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  logic [2:0]    src_sel,
    input  logic [2:0]    fn_sel,
    input  logic [2:0]    dst_sel,
    input  logic [SW-1:0] d_nib,
    input  logic          cin,
    input  logic          f_shr_in,
    input  logic          f_shl_in,
    input  logic          q_shr_in,
    input  logic          q_shl_in,
    output logic [SW-1:0] y_nib,
    output logic [SW-1:0] f_nib,
    output logic [SW-1:0] q_nib,
    output logic          gp,
    output logic          gg,
    output logic          cout,
    output logic          c_top,
    output logic          nz
);
    typedef struct packed {
        logic [NREG-1:0][SW-1:0] rf;
        logic [SW-1:0]           q;
    } slice_st_t;

    slice_st_t     st_d, st_q;
    logic [SW-1:0] a_val, b_val, r_op, s_op, x_op, y_op, p_b, g_b, f_val;
    logic [SW:0]   c_b;
    logic          arith;

    // Operand selection and ALU
    always_comb begin
        a_val = st_q.rf[a_addr];
        b_val = st_q.rf[b_addr];
        unique case (src_e'(src_sel))
            SRC_AQ:  begin r_op = a_val; s_op = st_q.q; end
            SRC_AB:  begin r_op = a_val; s_op = b_val;  end
            SRC_ZQ:  begin r_op = '0;    s_op = st_q.q; end
            SRC_ZB:  begin r_op = '0;    s_op = b_val;  end
            SRC_ZA:  begin r_op = '0;    s_op = a_val;  end
            SRC_DA:  begin r_op = d_nib; s_op = a_val;  end
            SRC_DQ:  begin r_op = d_nib; s_op = st_q.q; end
            default: begin r_op = d_nib; s_op = '0;     end
        endcase

        arith = 1'b1;
        x_op  = r_op;
        y_op  = s_op;
        unique case (fn_e'(fn_sel))
            FN_ADD:  ;
            FN_SUBR: x_op = ~r_op;
            FN_SUBS: y_op = ~s_op;
            default: arith = 1'b0;
        endcase

        p_b = arith ? (x_op ^ y_op) : '0;
        g_b = arith ? (x_op & y_op) : '0;
        c_b[0] = cin;
        for (int k = 0; k < SW; k++) c_b[k+1] = g_b[k] | (p_b[k] & c_b[k]);

        gg = 1'b0;
        for (int k = 0; k < SW; k++) gg = g_b[k] | (p_b[k] & gg);
        gp = &p_b;

        unique case (fn_e'(fn_sel))
            FN_OR:   f_val = r_op | s_op;
            FN_AND:  f_val = r_op & s_op;
            FN_XOR:  f_val = r_op ^ s_op;
            FN_XNOR: f_val = ~(r_op ^ s_op);
            FN_PASS: f_val = r_op;
            default: f_val = p_b ^ c_b[SW-1:0];
        endcase
    end

    // Destination decode and next state
    always_comb begin
        st_d  = st_q;
        y_nib = f_val;
        unique case (dst_e'(dst_sel))
            DST_QREG:  st_d.q = f_val;
            DST_NOP:   ;
            DST_RAMA:  begin st_d.rf[b_addr] = f_val; y_nib = a_val; end
            DST_RAMF:  st_d.rf[b_addr] = f_val;
            DST_RAMQD: begin
                st_d.rf[b_addr] = {f_shr_in, f_val[SW-1:1]};
                st_d.q          = {q_shr_in, st_q.q[SW-1:1]};
            end
            DST_RAMD:  st_d.rf[b_addr] = {f_shr_in, f_val[SW-1:1]};
            DST_RAMQU: begin
                st_d.rf[b_addr] = {f_val[SW-2:0], f_shl_in};
                st_d.q          = {st_q.q[SW-2:0], q_shl_in};
            end
            default:   st_d.rf[b_addr] = {f_val[SW-2:0], f_shl_in};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign f_nib = f_val;
    assign q_nib = st_q.q;
    assign cout  = c_b[SW];
    assign c_top = c_b[SW-1];
    assign nz    = |f_val;
endmodule

// File: rtl/bitslice_alu_array.sv
module bitslice_alu_array
    import bitslice_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    parameter int NREG       = 16,
    localparam int WIDTH = NUM_SLICES * SLICE_W,
    localparam int AW    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry_la,
    input  logic [AW-1:0]    a_addr,
    input  logic [AW-1:0]    b_addr,
    input  logic [2:0]       src_sel,
    input  logic [2:0]       fn_sel,
    input  logic [2:0]       dst_sel,
    input  logic [WIDTH-1:0] d_in,
    input  logic             c_in,
    input  logic [1:0]       msb_fill_sel,
    input  logic [1:0]       lsb_fill_sel,
    output logic [WIDTH-1:0] y,
    output logic             c_out,
    output logic             zero,
    output logic             sign,
    output logic             ovf
);
    logic [WIDTH-1:0]      f_word, q_word;
    logic [NUM_SLICES-1:0] gp_v, gg_v, cout_v, ctop_v, nz_v, cin_v, la_c;
    logic                  la_cout, word_cout;
    logic                  f_fill_r, f_fill_l, q_fill_r, q_fill_l;

    // End-of-chain fill multiplexers
    always_comb begin
        unique case (fill_e'(msb_fill_sel))
            FILL_ZERO: begin f_fill_r = 1'b0;           q_fill_r = 1'b0;           end
            FILL_ONE:  begin f_fill_r = 1'b1;           q_fill_r = 1'b1;           end
            FILL_ROT:  begin f_fill_r = f_word[0];       q_fill_r = q_word[0];       end
            default:   begin f_fill_r = f_word[WIDTH-1]; q_fill_r = q_word[WIDTH-1]; end
        endcase
        unique case (fill_e'(lsb_fill_sel))
            FILL_ONE:  begin f_fill_l = 1'b1;           q_fill_l = 1'b1;           end
            FILL_ROT:  begin f_fill_l = f_word[WIDTH-1]; q_fill_l = q_word[WIDTH-1]; end
            default:   begin f_fill_l = 1'b0;           q_fill_l = 1'b0;           end
        endcase
    end

    bitslice_carry_tree #(.NUM_SLICES(NUM_SLICES)) u_tree (
        .gp  (gp_v),
        .gg  (gg_v),
        .cin (c_in),
        .c   (la_c),
        .cout(la_cout)
    );

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        logic rip_cin, f_shr, f_shl, q_shr, q_shl;

        if (i == 0) begin : g_lo
            assign rip_cin = c_in;
            assign f_shl   = f_fill_l;
            assign q_shl   = q_fill_l;
        end else begin : g_mid_lo
            assign rip_cin = cout_v[i-1];
            assign f_shl   = f_word[i*SLICE_W-1];
            assign q_shl   = q_word[i*SLICE_W-1];
        end

        if (i == NUM_SLICES - 1) begin : g_hi
            assign f_shr = f_fill_r;
            assign q_shr = q_fill_r;
        end else begin : g_mid_hi
            assign f_shr = f_word[(i+1)*SLICE_W];
            assign q_shr = q_word[(i+1)*SLICE_W];
        end

        assign cin_v[i] = carry_la ? la_c[i] : rip_cin;

        bitslice_slice #(.NREG(NREG)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_addr  (a_addr),
            .b_addr  (b_addr),
            .src_sel (src_sel),
            .fn_sel  (fn_sel),
            .dst_sel (dst_sel),
            .d_nib   (d_in[i*SLICE_W +: SLICE_W]),
            .cin     (cin_v[i]),
            .f_shr_in(f_shr),
            .f_shl_in(f_shl),
            .q_shr_in(q_shr),
            .q_shl_in(q_shl),
            .y_nib   (y[i*SLICE_W +: SLICE_W]),
            .f_nib   (f_word[i*SLICE_W +: SLICE_W]),
            .q_nib   (q_word[i*SLICE_W +: SLICE_W]),
            .gp      (gp_v[i]),
            .gg      (gg_v[i]),
            .cout    (cout_v[i]),
            .c_top   (ctop_v[i]),
            .nz      (nz_v[i])
        );
    end

    assign word_cout = carry_la ? la_cout : cout_v[NUM_SLICES-1];
    assign c_out     = word_cout;
    assign zero      = ~|nz_v;
    assign sign      = f_word[WIDTH-1];
    assign ovf       = ctop_v[NUM_SLICES-1] ^ word_cout;
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       fn_sel,
    input logic [2:0]       src_sel,
    input logic [2:0]       dst_sel,
    input logic             c_in,
    input logic             c_out,
    input logic             ovf,
    input logic             zero,
    input logic [WIDTH-1:0] f_word,
    input logic [WIDTH-1:0] q_word
);
    // R7: wired-AND zero agrees with the assembled result word
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (f_word == '0));

    // R3: logic functions never carry or overflow
    assert_logic_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel >= 3'd3) |-> (!c_out && !ovf));

    // R2: D plus zero with no carry in cannot carry out
    assert_pass_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 3'd0 && src_sel == 3'd7 && !c_in) |-> !c_out);

    // R12: no-write destination keeps Q
    assert_nop_keeps_q_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == 3'd1) |=> (q_word == $past(q_word)));
endmodule

bind bitslice_alu_array bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fn_sel (fn_sel),
    .src_sel(src_sel),
    .dst_sel(dst_sel),
    .c_in   (c_in),
    .c_out  (c_out),
    .ovf    (ovf),
    .zero   (zero),
    .f_word (f_word),
    .q_word (q_word)
);

// File: tb/sim_bitslice_alu_array.sv
`timescale 1ns/1ps
module sim_bitslice_alu_array;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          carry_la = 1'b0;
    logic [3:0]    a_addr = '0, b_addr = '0;
    logic [2:0]    src_sel = '0, fn_sel = '0, dst_sel = 3'd1;
    logic [W-1:0]  d_in = '0;
    logic          c_in = 1'b0;
    logic [1:0]    msb_fill_sel = '0, lsb_fill_sel = '0;
    logic [W-1:0]  y;
    logic          c_out, zero, sign, ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [W+3:0] v;
        string        tag;
    } exp_t;
    exp_t sbq[$];

    logic [W-1:0] m_rf [16];
    logic [W-1:0] m_q;

    always #2.5 clk = ~clk;

    bitslice_alu_array u0 (
        .clk(clk), .rst_n(rst_n), .carry_la(carry_la),
        .a_addr(a_addr), .b_addr(b_addr), .src_sel(src_sel), .fn_sel(fn_sel),
        .dst_sel(dst_sel), .d_in(d_in), .c_in(c_in),
        .msb_fill_sel(msb_fill_sel), .lsb_fill_sel(lsb_fill_sel),
        .y(y), .c_out(c_out), .zero(zero), .sign(sign), .ovf(ovf)
    );

    function automatic logic fill_r(input logic [1:0] sel, input logic [W-1:0] v);
        case (sel)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return v[0];
            default: return v[W-1];
        endcase
    endfunction

    function automatic logic fill_l(input logic [1:0] sel, input logic [W-1:0] v);
        case (sel)
            2'd1: return 1'b1;
            2'd2: return v[W-1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic op(input logic [3:0] a, input logic [3:0] b, input logic [2:0] src,
                      input logic [2:0] fn, input logic [2:0] dst, input logic [W-1:0] d,
                      input logic cin, input logic [1:0] mf, input logic [1:0] lf,
                      input string tag);
        logic [W-1:0] av, bv, r, s, x, yv, f, yo;
        logic [W:0]   full;
        logic [W-1:0] low;
        logic         co, ov, ar;
        exp_t         e;
        av = m_rf[a]; bv = m_rf[b];
        case (src)
            3'd0: begin r = av; s = m_q; end
            3'd1: begin r = av; s = bv;  end
            3'd2: begin r = '0; s = m_q; end
            3'd3: begin r = '0; s = bv;  end
            3'd4: begin r = '0; s = av;  end
            3'd5: begin r = d;  s = av;  end
            3'd6: begin r = d;  s = m_q; end
            default: begin r = d; s = '0; end
        endcase
        ar = 1'b1; x = r; yv = s;
        case (fn)
            3'd0: ;
            3'd1: x = ~r;
            3'd2: yv = ~s;
            default: ar = 1'b0;
        endcase
        if (ar) begin
            full = {1'b0, x} + {1'b0, yv} + {{W{1'b0}}, cin};
            low  = {1'b0, x[W-2:0]} + {1'b0, yv[W-2:0]} + {{(W-1){1'b0}}, cin};
            f = full[W-1:0]; co = full[W]; ov = low[W-1] ^ co;
        end else begin
            co = 1'b0; ov = 1'b0;
            case (fn)
                3'd3: f = r | s;
                3'd4: f = r & s;
                3'd5: f = r ^ s;
                3'd6: f = ~(r ^ s);
                default: f = r;
            endcase
        end
        yo = (dst == 3'd2) ? av : f;

        @(negedge clk);
        a_addr = a; b_addr = b; src_sel = src; fn_sel = fn; dst_sel = dst;
        d_in = d; c_in = cin; msb_fill_sel = mf; lsb_fill_sel = lf;
        e.v = {yo, co, (f == '0), f[W-1], ov};
        e.tag = tag;
        sbq.push_back(e);

        case (dst)
            3'd0: m_q = f;
            3'd1: ;
            3'd2, 3'd3: m_rf[b] = f;
            3'd4: begin
                m_rf[b] = {fill_r(mf, f), f[W-1:1]};
                m_q = {fill_r(mf, m_q), m_q[W-1:1]};
            end
            3'd5: m_rf[b] = {fill_r(mf, f), f[W-1:1]};
            3'd6: begin
                m_rf[b] = {f[W-2:0], fill_l(lf, f)};
                m_q = {m_q[W-2:0], fill_l(lf, m_q)};
            end
            default: m_rf[b] = {f[W-2:0], fill_l(lf, f)};
        endcase
    endtask

    // Shorthand: load register k with value v
    task automatic load(input logic [3:0] k, input logic [W-1:0] v);
        op(4'd0, k, 3'd7, 3'd0, 3'd3, v, 1'b0, 2'd0, 2'd0, "R5 load");
    endtask

    // Shorthand: read register k onto y without writing
    task automatic rd(input logic [3:0] k, input string tag);
        op(4'd0, k, 3'd3, 3'd0, 3'd1, '0, 1'b0, 2'd0, 2'd0, tag);
    endtask

    task automatic rdq(input string tag);
        op(4'd0, 4'd0, 3'd2, 3'd0, 3'd1, '0, 1'b0, 2'd0, 2'd0, tag);
    endtask

    task automatic cmp(input logic [W+3:0] act, input logic [W+3:0] exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual y=%h c=%b z=%b s=%b v=%b expected y=%h c=%b z=%b s=%b v=%b",
                     tag, act[W+3:4], act[3], act[2], act[1], act[0],
                     exp_v[W+3:4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    // Monitor: checks ripple mode, then lookahead mode within the same cycle
    initial begin
        exp_t e;
        logic [W+3:0] rip;
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                rip = {y, c_out, zero, sign, ovf};
                cmp(rip, e.v, e.tag);
                carry_la = 1'b1;
                #1;
                cmp({y, c_out, zero, sign, ovf}, rip, {"R6 lookahead vs ripple, ", e.tag});
                carry_la = 1'b0;
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_rf[i] = '0;
        m_q = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd5, "R1 reg after reset");
        rd(4'd15, "R1 reg after reset");
        rdq("R1 Q after reset");

        for (int k = 0; k < 16; k++) load(4'(k), 32'h1357_9BDF * (k + 1) ^ 32'h0F0F_3C3C);
        for (int k = 0; k < 16; k += 5) rd(4'(k), "R5 readback");

        // R2: arithmetic codes and carry in
        op(4'd1, 4'd2, 3'd1, 3'd0, 3'd1, '0, 1'b0, 0, 0, "R2 add");
        op(4'd1, 4'd2, 3'd1, 3'd0, 3'd1, '0, 1'b1, 0, 0, "R2 add cin");
        op(4'd3, 4'd4, 3'd1, 3'd1, 3'd1, '0, 1'b1, 0, 0, "R2 subr");
        op(4'd3, 4'd4, 3'd1, 3'd2, 3'd1, '0, 1'b1, 0, 0, "R2 subs");
        op(4'd3, 4'd4, 3'd1, 3'd2, 3'd1, '0, 1'b0, 0, 0, "R2 subs borrow");

        // R3: logic codes
        for (int f = 3; f < 8; f++)
            op(4'd6, 4'd7, 3'd1, 3'(f), 3'd1, '0, 1'b1, 0, 0, "R3 logic");

        // R4: every source pair
        op(4'd8, 4'd0, 3'd6, 3'd0, 3'd0, 32'h0000_1234, 1'b0, 0, 0, "R5 Q write");
        for (int s = 0; s < 8; s++)
            op(4'd9, 4'd10, 3'(s), 3'd0, 3'd1, 32'hA5A5_0F0F, 1'b0, 0, 0, "R4 source");

        // R5: RAMA outputs A while writing F; R7 zero from F not y
        op(4'd11, 4'd12, 3'd1, 3'd2, 3'd2, '0, 1'b1, 0, 0, "R5 rama");
        rd(4'd12, "R5 rama write");
        op(4'd11, 4'd11, 3'd1, 3'd2, 3'd2, '0, 1'b1, 0, 0, "R7 zero with rama");
        op(4'd13, 4'd13, 3'd1, 3'd1, 3'd1, '0, 1'b1, 0, 0, "R7 equal subtract");

        // R13, R8: carry across seams, signed overflow
        load(4'd1, 32'hFFFF_FFFF);
        load(4'd2, 32'h0000_0001);
        op(4'd1, 4'd2, 3'd1, 3'd0, 3'd1, '0, 1'b0, 0, 0, "R13 all-ones plus one");
        load(4'd3, 32'h7FFF_FFFF);
        op(4'd3, 4'd2, 3'd1, 3'd0, 3'd1, '0, 1'b0, 0, 0, "R8 positive overflow");
        load(4'd4, 32'h8000_0000);
        op(4'd4, 4'd2, 3'd1, 3'd2, 3'd1, '0, 1'b1, 0, 0, "R8 negative overflow");
        op(4'd4, 4'd4, 3'd1, 3'd0, 3'd1, '0, 1'b0, 0, 0, "R8 min plus min");

        // R9, R10: register shifts with every fill
        for (int m = 0; m < 4; m++) begin
            load(4'd5, 32'h8000_0001);
            op(4'd0, 4'd5, 3'd3, 3'd0, 3'd5, '0, 1'b0, 2'(m), 0, "R9 right fill");
            rd(4'd5, "R9 right fill result");
            load(4'd6, 32'hC000_0002);
            op(4'd0, 4'd6, 3'd3, 3'd0, 3'd7, '0, 1'b0, 0, 2'(m), "R10 left fill");
            rd(4'd6, "R10 left fill result");
        end

        // R11: Q shifts with every fill
        for (int m = 0; m < 4; m++) begin
            op(4'd0, 4'd0, 3'd7, 3'd0, 3'd0, 32'h8421_0001, 1'b0, 0, 0, "R11 Q set");
            op(4'd0, 4'd7, 3'd2, 3'd0, 3'd4, '0, 1'b0, 2'(m), 0, "R11 Q right");
            rdq("R11 Q right result");
            op(4'd0, 4'd0, 3'd7, 3'd0, 3'd0, 32'h8000_1248, 1'b0, 0, 0, "R11 Q set");
            op(4'd0, 4'd7, 3'd2, 3'd0, 3'd6, '0, 1'b0, 0, 2'(m), "R11 Q left");
            rdq("R11 Q left result");
        end

        // R12: no-write destination
        load(4'd9, 32'hDEAD_BEEF);
        op(4'd0, 4'd9, 3'd7, 3'd0, 3'd1, 32'h1111_2222, 1'b0, 0, 0, "R12 nop op");
        rd(4'd9, "R12 reg unchanged");
        rdq("R12 Q unchanged");

        // R6: random microinstructions in both carry modes
        for (int n = 0; n < 400; n++)
            op(4'($urandom), 4'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
               (n % 7 == 0) ? 32'hFFFF_FFFF : $urandom, 1'($urandom),
               2'($urandom), 2'($urandom), "R6 random");
        for (int k = 0; k < 16; k++) rd(4'(k), "R5 final readback");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule